// File: doc/BRIEF.md
# Sequenced Dual Reset Controller

This block turns two digital supply-good indications into two ordered active-low reset outputs. The first input reports the master supply. The second reports a secondary supply. The first reset follows the master supply alone. The second reset follows both supplies, and it may only be released once the first reset is already free. On power-down, or on a manual reset, the second reset always drops before the first. The gap between the two falling edges is a parameter of at least one clock cycle.

Every release delay is a count of clock cycles. The first reset has a fixed timeout. The second reset uses either a fixed timeout or a period read from an input bus, and a mode input chooses between them. An active-low manual reset input forces both outputs low once it has been seen low for a minimum number of cycles. Shorter pulses are rejected. All three asynchronous inputs pass through two-flop synchronizers before any logic uses them.

Top module: `seq_reset_ctrl`

## Requirements
- R1: After reset, both outputs are low (asserted) and both timeout counters are cleared.
- R2: When the master supply input goes high, `rst1_n_o` rises on the (T1_CYC+2)-th rising clock edge after the change. Two of those edges are synchronizer latency.
- R3: In fixed mode (`t2_prog_sel_i`=0), the count for `rst2_n_o` starts only after `rst1_n_o` is high and the secondary input is high. `rst2_n_o` rises on the T2_FIX_CYC-th edge after the edge that released `rst1_n_o`. If `rst1_n_o` is already free, it rises on the (T2_FIX_CYC+2)-th edge after the secondary input rises.
- R4: In programmable mode (`t2_prog_sel_i`=1), the period is `t2_prog_cyc_i`, an unsigned cycle count. A value of zero acts as one.
- R5: When the master supply input falls, `rst2_n_o` falls on the 3rd edge after the change. `rst1_n_o` falls STAGGER_CYC edges after that. `rst1_n_o` is never low while `rst2_n_o` is high.
- R6: When the secondary input falls while the master supply stays good, `rst2_n_o` falls on the 3rd edge and `rst1_n_o` stays high. The secondary input never changes `rst1_n_o`.
- R7: If the input that a running timeout waits on turns bad again, that timeout restarts from zero. The full period is then counted from the next good edge.
- R8: A manual reset input held low for at least MR_FILT_CYC synchronized cycles drives `rst2_n_o` low on the (MR_FILT_CYC+3)-th edge. `rst1_n_o` follows STAGGER_CYC edges later. After the input returns high, `rst1_n_o` rises on the (T1_CYC+3)-th edge, and `rst2_n_o` then follows its normal timeout.
- R9: A manual reset low pulse shorter than MR_FILT_CYC synchronized cycles has no effect on either output.
- R10: A master supply dip that is seen for fewer than STAGGER_CYC edges asserts `rst2_n_o` but leaves `rst1_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_ok_i | input | 1 | Master supply good (1 = above threshold), asynchronous |
| sec_ok_i | input | 1 | Secondary supply good (1 = above threshold), asynchronous |
| mr_n_i | input | 1 | Manual reset, active low, asynchronous |
| t2_prog_sel_i | input | 1 | Mode for the second timeout: 0 = fixed, 1 = programmable |
| t2_prog_cyc_i | input | T2_PROG_W | Programmable period for the second reset, in cycles |
| rst1_n_o | output | 1 | First reset, active low |
| rst2_n_o | output | 1 | Second reset, active low |

## Verification
Every result has a fixed edge count from its stimulus. A supply loss reaches `rst2_n_o` after 3 edges and `rst1_n_o` after STAGGER_CYC more. A release takes the timeout plus 2 edges, with one extra edge on the manual-reset path for the filter flag. The second reset is counted from the edge that released the first. The bench applies each stimulus on a falling clock edge. It then counts rising edges until the output changes, reading the output at each following falling edge, and compares that count with the latency computed from the parameters. Where an output must not move, the bench watches it for a window longer than any latency that could apply and expects no change.

// File: rtl/seq_rst_pkg.sv
package seq_rst_pkg;

  // True on the edge that completes a timeout of lim cycles (lim 0 acts as 1).
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  // Period for the second reset: fixed count or the programmed count.
  function automatic int unsigned pick_t2(input logic prog_sel, input int unsigned fix_cyc,
                                          input int unsigned prog_cyc);
    return prog_sel ? prog_cyc : fix_cyc;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mr_glitch_filter.sv
module mr_glitch_filter
  import seq_rst_pkg::*;
#(
  parameter int unsigned FILT_CYC = 4,
  localparam int unsigned FW = $clog2(FILT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_hold
);

  logic [FW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (mr_n_s) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (!hold_q) begin
      if (limit_hit(32'(cnt_q), FILT_CYC)) hold_q <= 1'b1;
      else                                  cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign mr_hold = hold_q;

endmodule

// File: rtl/rst1_stage.sv
module rst1_stage
  import seq_rst_pkg::*;
#(
  parameter int unsigned T1_CYC      = 40,
  parameter int unsigned STAGGER_CYC = 2,
  parameter int unsigned W           = 8,
  localparam int unsigned SW = $clog2(STAGGER_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m_bad,
  output logic rst1_n
);

  logic [W-1:0]  cnt_q;
  logic [SW-1:0] stg_q;
  logic          asrt_q;
  logic          stg_done;

  assign stg_done = (stg_q == SW'(STAGGER_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stg_q  <= '0;
      asrt_q <= 1'b1;
    end else if (m_bad) begin
      cnt_q <= '0;
      if (stg_done) asrt_q <= 1'b1;
      else          stg_q  <= stg_q + 1'b1;
    end else begin
      stg_q <= '0;
      if (asrt_q) begin
        if (limit_hit(32'(cnt_q), T1_CYC)) begin
          asrt_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rst1_n = ~asrt_q;

endmodule

// File: rtl/rst2_stage.sv
module rst2_stage
  import seq_rst_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_bad,
  input  logic         rst1_n,
  input  logic [W-1:0] lim,
  output logic         rst2_n
);

  logic [W-1:0] cnt_q;
  logic         asrt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      asrt_q <= 1'b1;
    end else if (s_bad) begin
      cnt_q  <= '0;
      asrt_q <= 1'b1;
    end else if (asrt_q && rst1_n) begin
      if (limit_hit(32'(cnt_q), 32'(lim))) begin
        asrt_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign rst2_n = ~asrt_q;

endmodule

// File: rtl/seq_reset_ctrl.sv
module seq_reset_ctrl
  import seq_rst_pkg::*;
#(
  parameter int unsigned T1_CYC      = 40,
  parameter int unsigned T2_FIX_CYC  = 60,
  parameter int unsigned T2_PROG_W   = 8,
  parameter int unsigned STAGGER_CYC = 2,
  parameter int unsigned MR_FILT_CYC = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_MAX = max3(T1_CYC, T2_FIX_CYC, (32'd1 << T2_PROG_W) - 32'd1),
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mst_ok_i,
  input  logic                 sec_ok_i,
  input  logic                 mr_n_i,
  input  logic                 t2_prog_sel_i,
  input  logic [T2_PROG_W-1:0] t2_prog_cyc_i,
  output logic                 rst1_n_o,
  output logic                 rst2_n_o
);

  // Synchronized inputs: bit 2 manual reset, bit 1 secondary, bit 0 master.
  logic [2:0] in_s;
  logic       mr_hold;
  logic       m_bad;   // master lost or manual reset held
  logic       s_bad;   // anything that must hold the second reset
  logic [CNT_W-1:0] t2_lim;

  sync_bank #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mr_n_i, sec_ok_i, mst_ok_i}),
    .q     (in_s)
  );

  mr_glitch_filter #(
    .FILT_CYC (MR_FILT_CYC)
  ) u_mrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .mr_n_s  (in_s[2]),
    .mr_hold (mr_hold)
  );

  assign m_bad  = ~in_s[0] | mr_hold;
  assign s_bad  = m_bad | ~in_s[1];
  assign t2_lim = CNT_W'(pick_t2(t2_prog_sel_i, T2_FIX_CYC, 32'(t2_prog_cyc_i)));

  rst1_stage #(
    .T1_CYC      (T1_CYC),
    .STAGGER_CYC (STAGGER_CYC),
    .W           (CNT_W)
  ) u_r1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .m_bad  (m_bad),
    .rst1_n (rst1_n_o)
  );

  rst2_stage #(
    .W (CNT_W)
  ) u_r2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_bad  (s_bad),
    .rst1_n (rst1_n_o),
    .lim    (t2_lim),
    .rst2_n (rst2_n_o)
  );

endmodule

// File: rtl/seq_rst_chk.sv
module seq_rst_chk (
  input logic clk,
  input logic rst_n,
  input logic m_bad,
  input logic s_bad,
  input logic mr_hold,
  input logic rst1_n,
  input logic rst2_n
);

  AST_ORDER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !rst1_n |-> !rst2_n);                                      // R5

  AST_R2_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst1_n) |-> $past(!rst2_n));                         // R5

  AST_R2_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    s_bad |=> !rst2_n);                                        // R6

  AST_R2_AFTER_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst2_n) |-> $past(rst1_n));                          // R3

  AST_R1_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_bad && rst1_n) |=> rst1_n);                            // R6

  AST_R1_GOOD_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst1_n) |-> $past(!m_bad));                          // R2

  AST_MR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    mr_hold |=> !rst2_n);                                      // R8

endmodule

bind seq_reset_ctrl seq_rst_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_bad   (m_bad),
  .s_bad   (s_bad),
  .mr_hold (mr_hold),
  .rst1_n  (rst1_n_o),
  .rst2_n  (rst2_n_o)
);

// File: tb/tb_seq_reset_ctrl.sv
module tb_seq_reset_ctrl;

  localparam int T1  = 40;
  localparam int T2F = 60;
  localparam int PW  = 8;
  localparam int STG = 2;
  localparam int MRF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic mst_ok, sec_ok, mr_n, sel;
  logic [PW-1:0] prog;
  logic rst1_n, rst2_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  seq_reset_ctrl #(
    .T1_CYC (T1), .T2_FIX_CYC (T2F), .T2_PROG_W (PW),
    .STAGGER_CYC (STG), .MR_FILT_CYC (MRF), .SYNC_STAGES (2)
  ) dut (
    .clk (clk), .rst_n (rst_n), .mst_ok_i (mst_ok), .sec_ok_i (sec_ok),
    .mr_n_i (mr_n), .t2_prog_sel_i (sel), .t2_prog_cyc_i (prog),
    .rst1_n_o (rst1_n), .rst2_n_o (rst2_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Count rising edges until the chosen output reads lvl at a falling edge; -1 if never.
  task automatic wait_change(input int which, input logic lvl, input int maxc, output int lat);
    lat = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (((which == 1) ? rst1_n : rst2_n) == lvl) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; mst_ok = 1'b0; sec_ok = 1'b0; mr_n = 1'b1; sel = 1'b0; prog = '0;
    idle(4);
    chk("R1 rst1_n in reset", int'(rst1_n), 0);
    chk("R1 rst2_n in reset", int'(rst2_n), 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 rst1_n after reset", int'(rst1_n), 0);
    chk("R1 rst2_n after reset", int'(rst2_n), 0);
  endtask

  task automatic t_power_up;
    int lat;
    mst_ok = 1'b1; sec_ok = 1'b1;
    wait_change(1, 1'b1, T1 + 10, lat);
    chk("R2 rst1 release latency", lat, T1 + 2);
    chk("R3 rst2 still held at rst1 release", int'(rst2_n), 0);
    wait_change(2, 1'b1, T2F + 10, lat);
    chk("R3 rst2 fixed release after rst1", lat, T2F);
  endtask

  task automatic t_secondary;
    int lat;
    sec_ok = 1'b0;
    wait_change(2, 1'b0, 10, lat);
    chk("R6 rst2 assert on secondary loss", lat, 3);
    wait_change(1, 1'b0, 50, lat);
    chk("R6 rst1 unaffected by secondary", lat, -1);
    sec_ok = 1'b1;
    wait_change(2, 1'b1, T2F + 10, lat);
    chk("R3 rst2 fixed release on secondary return", lat, T2F + 2);
  endtask

  task automatic t_prog;
    int lat;
    sel = 1'b1; prog = 8'd10;
    sec_ok = 1'b0;
    wait_change(2, 1'b0, 10, lat);
    chk("R6 rst2 assert in prog mode", lat, 3);
    sec_ok = 1'b1;
    wait_change(2, 1'b1, 40, lat);
    chk("R4 rst2 prog release", lat, 12);
    // restart during a running count
    sec_ok = 1'b0;
    wait_change(2, 1'b0, 10, lat);
    sec_ok = 1'b1;
    idle(5);
    chk("R7 rst2 still held mid count", int'(rst2_n), 0);
    sec_ok = 1'b0;
    idle(4);
    sec_ok = 1'b1;
    wait_change(2, 1'b1, 40, lat);
    chk("R7 rst2 count restarts from zero", lat, 12);
    prog = 8'd0;
    sec_ok = 1'b0;
    wait_change(2, 1'b0, 10, lat);
    sec_ok = 1'b1;
    wait_change(2, 1'b1, 20, lat);
    chk("R4 zero period acts as one", lat, 3);
    sel = 1'b0;
  endtask

  task automatic t_master;
    int lat;
    mst_ok = 1'b0;
    wait_change(2, 1'b0, 10, lat);
    chk("R5 rst2 assert on master loss", lat, 3);
    chk("R5 rst1 still high when rst2 falls", int'(rst1_n), 1);
    wait_change(1, 1'b0, 10, lat);
    chk("R5 rst1 stagger", lat, STG);
    mst_ok = 1'b1;
    idle(10);
    mst_ok = 1'b0;
    idle(5);
    mst_ok = 1'b1;
    wait_change(1, 1'b1, T1 + 20, lat);
    chk("R7 rst1 count restarts from zero", lat, T1 + 2);
    wait_change(2, 1'b1, T2F + 10, lat);
    chk("R3 rst2 release after rst1", lat, T2F);
  endtask

  task automatic t_dip;
    int lat;
    mst_ok = 1'b0;
    idle(1);
    mst_ok = 1'b1;
    wait_change(2, 1'b0, 10, lat);
    chk("R10 rst2 assert on short dip", lat, 2);
    wait_change(1, 1'b0, 20, lat);
    chk("R10 rst1 ignores short dip", lat, -1);
    wait_change(2, 1'b1, T2F + 10, lat);
    chk("R10 rst2 recovers after dip", lat, T2F - 20);
  endtask

  task automatic t_manual;
    int lat;
    mr_n = 1'b0;
    wait_change(2, 1'b0, 20, lat);
    chk("R8 rst2 assert on manual reset", lat, MRF + 3);
    wait_change(1, 1'b0, 10, lat);
    chk("R8 rst1 follows after stagger", lat, STG);
    wait_change(1, 1'b1, 30, lat);
    chk("R8 rst1 held while manual reset low", lat, -1);
    mr_n = 1'b1;
    wait_change(1, 1'b1, T1 + 10, lat);
    chk("R8 rst1 release after manual reset", lat, T1 + 3);
    wait_change(2, 1'b1, T2F + 10, lat);
    chk("R8 rst2 release after manual reset", lat, T2F);
  endtask

  task automatic t_glitch;
    int lat;
    mr_n = 1'b0;
    idle(MRF - 1);
    mr_n = 1'b1;
    wait_change(2, 1'b0, 15, lat);
    chk("R9 short manual pulse ignored rst2", lat, -1);
    chk("R9 short manual pulse ignored rst1", int'(rst1_n), 1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_power_up();
    t_secondary();
    t_prog();
    t_master();
    t_dip();
    t_manual();
    t_glitch();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule